// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of a single-rank 16-bit SDR SDRAM with a 12-bit address bus and two bank-select lines. When reset is released it brings the memory up in a fixed order. It raises clock enable and holds NOP for the power-up wait. It then issues a precharge of all banks, a run of auto-refresh commands, and a load-mode command that carries the mode word on the address bus. After that it enters normal operation and issues an auto-refresh every time a reload interval counter expires.

All timing values are parameters given in nanoseconds. At elaboration each one becomes a clock count, computed as the truncated value of `CLK_MHZ * ns / 1000` with a floor of one cycle. Two flags, `init_done` and `busy`, let a later read/write engine stay off the command pins during start-up and while a refresh is pending or recovering. Data transfers, row and bank tracking, the data path and pad clocking are handled by other logic.

Top module: `sdram_bringup_seq`

## Requirements
- R1: While `rst_n` is low, `cke` is low, the command is NOP ({cs_n,ras_n,cas_n,we_n} = 0111), `init_done` is low and `busy` is high.
- R2: After reset, `cke` rises and holds NOP for exactly `CLK_MHZ*POWERUP_US` cycles (20000 at defaults) before the first command.
- R3: The first command is precharge-all, encoded 0010, with address bit 10 high.
- R4: Exactly `INIT_REFRESHES` (8) auto-refresh commands, encoded 0001, follow. The first comes tRP cycles after the precharge and each later one comes tRFC cycles after the previous one. A cycle count is trunc(CLK_MHZ*ns/1000) with a minimum of 1, which gives tRP = 1 and tRFC = 6 at defaults.
- R5: A load-mode command (0000) follows tRFC cycles after the last start-up refresh. It drives the bank lines to 0 and the address bus to the mode word: burst code in bits [2:0] and CAS latency in bits [6:4], which is 0x030 at defaults.
- R6: `init_done` rises exactly tMRD (3) cycles after the load-mode command and stays high until reset.
- R7: In normal operation the first auto-refresh appears `REFRESH_COUNT+2` cycles after `init_done` rises. Later ones are spaced `REFRESH_COUNT+1` cycles apart (1387 at defaults).
- R8: `busy` is high whenever `init_done` is low. In normal operation it is high in the cycle before a refresh, in the refresh cycle and in the next tRFC-2 cycles, and low otherwise.
- R9: If the refresh interval is shorter than tRFC, expired requests are held and serviced as soon as recovery ends, so refreshes run back to back exactly tRFC cycles apart.
- R10: No command other than NOP is driven while `cke` is low, and once `cke` has risen it never falls before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W (2) | Bank address |
| addr | output | ADDR_W (12) | Address bus |
| init_done | output | 1 | Start-up sequence complete |
| busy | output | 1 | Command pins owned by the sequencer |

## Verification
A wrong step or repeat count shows up on the command pins before `init_done` rises. Examples are a missing or extra refresh, a shortened wait, or a bad mode word. These errors appear as a misplaced command, a wrong encoding or a wrong spacing within about 20100 cycles of reset. A faulty interval timer or a lost pending request only shows in normal operation. The bench catches it at the first or second periodic refresh, measured against `init_done`. It also uses a second instance with a short interval so that a dropped backlog shows within a few tRFC periods. Errors in the `busy` flag show at the cycle edges around the first periodic refresh.

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq #(
  parameter int CLK_MHZ        = 100,
  parameter int POWERUP_US     = 200,
  parameter int T_RP_NS        = 15,
  parameter int T_RFC_NS       = 63,
  parameter int T_MRD_CYC      = 3,
  parameter int INIT_REFRESHES = 8,
  parameter int REFRESH_COUNT  = 1386,
  parameter int BURST_CODE     = 0,
  parameter int CAS_LAT        = 3,
  parameter int ADDR_W         = 12,
  parameter int BA_W           = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              busy
);
  function automatic int to_cyc(input int ns);
    int c;
    c = (CLK_MHZ * ns) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int PWR_CYC  = CLK_MHZ * POWERUP_US;
  localparam int RP_CYC   = to_cyc(T_RP_NS);
  localparam int RFC_CYC  = to_cyc(T_RFC_NS);
  localparam int MRD_CYC  = (T_MRD_CYC < 1) ? 1 : T_MRD_CYC;
  localparam int MAX_A    = (PWR_CYC > RFC_CYC) ? PWR_CYC : RFC_CYC;
  localparam int MAX_B    = (RP_CYC > MRD_CYC) ? RP_CYC : MRD_CYC;
  localparam int WAIT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW       = $clog2(WAIT_MAX + 1);
  localparam int TW       = $clog2(REFRESH_COUNT + 1);
  localparam int NW       = $clog2(INIT_REFRESHES + 1);
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'((CAS_LAT % 8) * 16 + (BURST_CODE % 8));
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1 << 10);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  typedef enum logic [2:0] {S_CKE, S_PRE, S_REF, S_LMR, S_RUN} step_t;

  step_t             step;
  logic [CW-1:0]     wait_cnt;
  logic [NW-1:0]     ref_num;
  logic [TW-1:0]     ival;
  logic              pend;
  logic              done_q;
  logic              cke_q;
  logic [3:0]        cmd;
  logic [ADDR_W-1:0] addr_q;

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke       = cke_q;
  assign addr      = addr_q;
  assign ba        = '0;
  assign init_done = done_q;
  assign busy      = !done_q || pend || (wait_cnt != '0) || (cmd != C_NOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= S_CKE;
      wait_cnt <= '0;
      ref_num  <= '0;
      ival     <= '0;
      pend     <= 1'b0;
      done_q   <= 1'b0;
      cke_q    <= 1'b0;
      cmd      <= C_NOP;
      addr_q   <= '0;
    end else begin
      cmd    <= C_NOP;
      addr_q <= '0;
      if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 1'b1;
      end else begin
        case (step)
          S_CKE: begin
            cke_q    <= 1'b1;
            wait_cnt <= CW'(PWR_CYC - 1);
            step     <= S_PRE;
          end
          S_PRE: begin
            cmd      <= C_PRE;
            addr_q   <= ALL_BANKS;
            wait_cnt <= CW'(RP_CYC - 1);
            step     <= S_REF;
          end
          S_REF: begin
            cmd      <= C_REF;
            wait_cnt <= CW'(RFC_CYC - 1);
            ref_num  <= ref_num + 1'b1;
            if (ref_num == NW'(INIT_REFRESHES - 1)) step <= S_LMR;
          end
          S_LMR: begin
            cmd      <= C_LMR;
            addr_q   <= MODE_WORD;
            wait_cnt <= CW'(MRD_CYC - 1);
            step     <= S_RUN;
          end
          default: begin
            done_q <= 1'b1;
            if (!done_q) ival <= TW'(REFRESH_COUNT);
            if (pend) begin
              cmd      <= C_REF;
              wait_cnt <= CW'(RFC_CYC - 1);
              pend     <= 1'b0;
            end
          end
        endcase
      end
      if (done_q) begin
        if (ival == '0) begin
          ival <= TW'(REFRESH_COUNT);
          pend <= 1'b1;
        end else begin
          ival <= ival - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdram_bringup_chk.sv
module sdram_bringup_chk #(
  parameter int RP     = 1,
  parameter int RFC    = 6,
  parameter int MRD    = 3,
  parameter int ADDR_W = 12,
  parameter int MODE   = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic [3:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done,
  input logic              busy
);
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] LMR = 4'b0000;

  logic [15:0] gap;
  logic [3:0]  last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= 16'hFFFF;
      last <= NOP;
    end else if (cmd != NOP) begin
      gap  <= 16'd1;
      last <= cmd;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 16'd1;
    end
  end

  p_nop_before_cke_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cmd == NOP);
  p_cke_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  p_pre_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == PRE |-> addr[10]);
  p_pre_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != NOP && last == PRE) |-> gap >= 16'(RP));
  p_ref_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != NOP && last == REF) |-> gap >= 16'(RFC));
  p_mode_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == LMR |-> (addr == ADDR_W'(MODE) && !init_done));
  p_done_after_mrd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (last == LMR && gap >= 16'(MRD)));
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != NOP || !init_done) |-> busy);
endmodule

bind sdram_bringup_seq sdram_bringup_chk #(
  .RP(RP_CYC), .RFC(RFC_CYC), .MRD(MRD_CYC), .ADDR_W(ADDR_W), .MODE(int'(MODE_WORD))
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cmd({cs_n, ras_n, cas_n, we_n}),
  .addr(addr), .init_done(init_done), .busy(busy)
);

// File: tb/tb_sdram_bringup_seq.sv
module tb_sdram_bringup_seq;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] LMR = 4'b0000;
  localparam int PWR = 20000;
  localparam int TRP = 1;
  localparam int TRFC = 6;
  localparam int TMRD = 3;
  localparam int REFI = 1386;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done, busy;
  logic [1:0] ba;
  logic [11:0] addr;
  logic f_cke, f_cs_n, f_ras_n, f_cas_n, f_we_n, f_done, f_busy;
  logic [1:0] f_ba;
  logic [11:0] f_addr;

  int cyc = 0;
  int checks = 0;
  int failures = 0;

  int ev_cyc [0:15];
  logic [3:0] ev_cmd [0:15];
  logic [11:0] ev_addr [0:15];
  logic [1:0] ev_ba [0:15];
  int nev = 0;
  int cke_rise = -1;
  int done_rise = -1;
  int f_last = -1;
  int f_gap [0:3];
  int nf = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_bringup_seq dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done), .busy(busy));

  sdram_bringup_seq #(.POWERUP_US(1), .REFRESH_COUNT(2)) dut_fast (
    .clk(clk), .rst_n(rst_n), .cke(f_cke), .cs_n(f_cs_n), .ras_n(f_ras_n), .cas_n(f_cas_n),
    .we_n(f_we_n), .ba(f_ba), .addr(f_addr), .init_done(f_done), .busy(f_busy));

  always @(negedge clk) begin
    if (rst_n) begin
      if (cke && cke_rise < 0) cke_rise = cyc;
      if (init_done && done_rise < 0) done_rise = cyc;
      if ({cs_n, ras_n, cas_n, we_n} != NOP && nev < 16) begin
        ev_cyc[nev]  = cyc;
        ev_cmd[nev]  = {cs_n, ras_n, cas_n, we_n};
        ev_addr[nev] = addr;
        ev_ba[nev]   = ba;
        nev++;
      end
      if (f_done && {f_cs_n, f_ras_n, f_cas_n, f_we_n} == REF) begin
        if (f_last >= 0 && nf < 4) begin
          f_gap[nf] = cyc - f_last;
          nf++;
        end
        f_last = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(cke == 1'b0, "R1 cke in reset", int'(cke), 0);
    chk({cs_n, ras_n, cas_n, we_n} == NOP, "R1 command in reset", int'({cs_n, ras_n, cas_n, we_n}), int'(NOP));
    chk(init_done == 1'b0, "R1 init_done in reset", int'(init_done), 0);
    chk(busy == 1'b1, "R1 busy in reset", int'(busy), 1);
  endtask

  task automatic t_startup;
    while (!init_done) @(negedge clk);
    @(negedge clk);
    chk(nev == 10, "R4 start-up command count", nev, 10);
    chk(ev_cyc[0] - cke_rise == PWR, "R2 power-up NOP span", ev_cyc[0] - cke_rise, PWR);
    chk(ev_cmd[0] == PRE, "R3 first command code", int'(ev_cmd[0]), int'(PRE));
    chk(ev_addr[0][10] == 1'b1, "R3 precharge A10", int'(ev_addr[0][10]), 1);
    for (int i = 1; i <= 8; i++) begin
      chk(ev_cmd[i] == REF, "R4 start-up refresh code", int'(ev_cmd[i]), int'(REF));
      chk(ev_cyc[i] - ev_cyc[i-1] == ((i == 1) ? TRP : TRFC), "R4 start-up refresh spacing",
          ev_cyc[i] - ev_cyc[i-1], (i == 1) ? TRP : TRFC);
    end
    chk(ev_cmd[9] == LMR, "R5 load-mode code", int'(ev_cmd[9]), int'(LMR));
    chk(ev_addr[9] == 12'h030, "R5 mode word", int'(ev_addr[9]), 'h030);
    chk(ev_ba[9] == 2'b00, "R5 bank lines", int'(ev_ba[9]), 0);
    chk(ev_cyc[9] - ev_cyc[8] == TRFC, "R5 load-mode spacing", ev_cyc[9] - ev_cyc[8], TRFC);
    chk(done_rise - ev_cyc[9] == TMRD, "R6 init_done delay", done_rise - ev_cyc[9], TMRD);
  endtask

  task automatic t_busy;
    int t;
    t = done_rise + REFI + 2;
    wait_to(done_rise + 2);
    chk(busy == 1'b0, "R8 idle after init", int'(busy), 0);
    wait_to(t - 2);
    chk(busy == 1'b0, "R8 idle before request", int'(busy), 0);
    wait_to(t - 1);
    chk(busy == 1'b1, "R8 pending request", int'(busy), 1);
    wait_to(t + TRFC - 2);
    chk(busy == 1'b1, "R8 refresh recovery", int'(busy), 1);
    wait_to(t + TRFC - 1);
    chk(busy == 1'b0, "R8 release after recovery", int'(busy), 0);
    chk(init_done == 1'b1, "R6 init_done held", int'(init_done), 1);
  endtask

  task automatic t_periodic;
    while (nev < 12) @(negedge clk);
    @(negedge clk);
    chk(ev_cmd[10] == REF && ev_cmd[11] == REF, "R7 periodic refresh code",
        int'(ev_cmd[10]), int'(REF));
    chk(ev_cyc[10] - done_rise == REFI + 2, "R7 first periodic refresh", ev_cyc[10] - done_rise, REFI + 2);
    chk(ev_cyc[11] - ev_cyc[10] == REFI + 1, "R7 refresh period", ev_cyc[11] - ev_cyc[10], REFI + 1);
    chk(cke == 1'b1, "R10 cke held high", int'(cke), 1);
  endtask

  task automatic t_backlog;
    while (nf < 4) @(negedge clk);
    for (int i = 0; i < 4; i++)
      chk(f_gap[i] == TRFC, "R9 back-to-back refresh spacing", f_gap[i], TRFC);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog all requirements actual=%0d expected<60000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_startup();
    t_busy();
    t_periodic();
    t_backlog();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule